// File: doc/BRIEF.md
# Maskable Interrupt Status Unit

This block collects the interrupt sources of a two-wire serial bus controller into one eight-bit status view, filters that view through an eight-bit enable mask, and drives a single level-sensitive interrupt line toward the processor. The upper six status bits record events. Each is set by a one-cycle pulse from the controller and then holds its value until software clears it. The two lowest bits are not stored. They show, live, whether the transmit queue wants more data and whether the receive queue holds data to collect.

Software reaches the block through a simple register port with one write strobe, a one-bit write address, write data, and a one-bit read address with combinational read data. Address 0 selects the status view and address 1 selects the mask. A handler can read the status, do its work, and write the same value back. That write clears exactly the event bits it saw. An event that fires while the handler is working stays recorded. The packet-done source always drives the interrupt line, whatever its mask bit holds. This means a finished transfer is never lost, even if the mask was cleared while the handler was handling an error.

Top module: `irq_stat_unit`

## Requirements
- R1: After reset the stored event bits (status bits 7 to 2) are 0, every mask bit is 0 and irqOut is 0.
- R2: A pulse on evtPulse[k] (k = 0..5) sets status bit k+2 at that clock edge. The bit then reads 1 until it is cleared.
- R3: A write with wrAddr=0 clears each status bit in 7..2 whose wrData bit is 1 and leaves the others unchanged. Writing back the value just read clears exactly the bits that were set.
- R4: If an event pulse and a clearing write hit the same status bit in the same cycle, the bit stays set.
- R5: Status bit 1 reads txDataReq and status bit 0 reads rxDataReq, both live. A status write has no effect on them.
- R6: A write with wrAddr=1 loads the mask. A read with rdAddr=1 returns the mask and a read with rdAddr=0 returns the status. A mask bit of 1 enables the matching source.
- R7: irqOut is registered. At each clock edge it takes the OR over all bits of status AND effective mask. Because of this, irqOut rises one cycle after an enabled status bit first reads 1.
- R8: Status bit 7 (packet done) drives irqOut even when mask bit 7 is 0.
- R9: Mask bits never change the status view. A masked event is still recorded and can be read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| evtPulse | input | 6 | Event pulses for status bits 7..2 (bit 5 = packet done, 4 = all packets done, 3 = transmit overflow, 2 = receive underflow, 1 = no acknowledge, 0 = arbitration lost) |
| txDataReq | input | 1 | Live level: transmit queue wants data (status bit 1) |
| rxDataReq | input | 1 | Live level: receive queue holds data (status bit 0) |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 1 | Write target: 0 status (write-one-to-clear), 1 mask |
| wrData | input | 8 | Write data |
| rdAddr | input | 1 | Read target: 0 status, 1 mask |
| rdData | output | 8 | Combinational read data |
| irqOut | output | 1 | Registered interrupt line |

## Verification
The bench aims at several corner cases. The first is a clear and an event landing on the same bit in the same cycle: a design where the clear wins would lose the event and read 0. The second is a clear-write aimed at the two level bits: a design that stored those bits would drop them, or keep them stuck, instead of following the inputs. The third is packet-done with its mask bit at 0: a design that masked it uniformly would leave irqOut low. The fourth is the one-cycle delay of irqOut: a combinational line would rise one cycle early. Random traffic mixes events, partial clears, write-backs of read values and mask changes, so that stray bit corruption is also caught.

// File: rtl/irqs_pkg.sv
package irqs_pkg;
  localparam int NUM_SRC   = 8;
  localparam int NUM_LEVEL = 2;
  localparam int NUM_STICKY = NUM_SRC - NUM_LEVEL;
  localparam int ALWAYS_ON_BIT = NUM_SRC - 1;
  localparam logic [NUM_SRC-1:0] FORCE_EN = {1'b1, {(NUM_SRC-1){1'b0}}};

  typedef struct packed {
    logic               clrStat;
    logic               ldMask;
    logic [NUM_SRC-1:0] val;
  } regStrobe_t;
endpackage

// File: rtl/irqs_ctrl.sv
module irqs_ctrl
  import irqs_pkg::*;
(
  input  logic               wrEn,
  input  logic               wrAddr,
  input  logic [NUM_SRC-1:0] wrData,
  output regStrobe_t         strobe
);
  localparam logic ADDR_STATUS = 1'b0;
  localparam logic ADDR_MASK   = 1'b1;

  always_comb begin
    strobe.clrStat = wrEn && (wrAddr == ADDR_STATUS);
    strobe.ldMask  = wrEn && (wrAddr == ADDR_MASK);
    strobe.val     = wrData;
  end
endmodule

// File: rtl/irqs_dpath.sv
module irqs_dpath
  import irqs_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  regStrobe_t            strobe,
  input  logic [NUM_STICKY-1:0] evtPulse,
  input  logic [NUM_LEVEL-1:0]  lvlReq,
  input  logic                  rdAddr,
  output logic [NUM_SRC-1:0]    rdData,
  output logic [NUM_SRC-1:0]    statusView,
  output logic [NUM_SRC-1:0]    maskView,
  output logic                  irqOut
);
  logic [NUM_STICKY-1:0] stickyQ;
  logic [NUM_SRC-1:0]    maskQ;
  logic [NUM_SRC-1:0]    effEnable;
  logic                  irqNext;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_STICKY; gi++) begin : g_sticky
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          stickyQ[gi] <= 1'b0;
        end else if (evtPulse[gi]) begin
          stickyQ[gi] <= 1'b1;
        end else if (strobe.clrStat && strobe.val[gi+NUM_LEVEL]) begin
          stickyQ[gi] <= 1'b0;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskQ <= '0;
    end else if (strobe.ldMask) begin
      maskQ <= strobe.val;
    end
  end

  always_comb begin
    statusView = {stickyQ, lvlReq};
    maskView   = maskQ;
    effEnable  = maskQ | FORCE_EN;
    irqNext    = |(statusView & effEnable);
    rdData     = rdAddr ? maskQ : statusView;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqOut <= 1'b0;
    end else begin
      irqOut <= irqNext;
    end
  end
endmodule

// File: rtl/irq_stat_unit.sv
module irq_stat_unit
  import irqs_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NUM_STICKY-1:0] evtPulse,
  input  logic                  txDataReq,
  input  logic                  rxDataReq,
  input  logic                  wrEn,
  input  logic                  wrAddr,
  input  logic [NUM_SRC-1:0]    wrData,
  input  logic                  rdAddr,
  output logic [NUM_SRC-1:0]    rdData,
  output logic                  irqOut
);
  regStrobe_t         strobe;
  logic [NUM_SRC-1:0] statusView;
  logic [NUM_SRC-1:0] maskView;

  irqs_ctrl u_ctrl (
    .wrEn   (wrEn),
    .wrAddr (wrAddr),
    .wrData (wrData),
    .strobe (strobe)
  );

  irqs_dpath u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .evtPulse   (evtPulse),
    .lvlReq     ({txDataReq, rxDataReq}),
    .rdAddr     (rdAddr),
    .rdData     (rdData),
    .statusView (statusView),
    .maskView   (maskView),
    .irqOut     (irqOut)
  );
endmodule

// File: rtl/irq_stat_unit_chk.sv
module irq_stat_unit_chk
  import irqs_pkg::*;
(
  input logic                  clk,
  input logic                  rstN,
  input logic [NUM_STICKY-1:0] evtPulse,
  input logic                  wrEn,
  input logic                  wrAddr,
  input logic [NUM_SRC-1:0]    wrData,
  input logic [NUM_SRC-1:0]    statusView,
  input logic [NUM_SRC-1:0]    maskView,
  input logic                  irqOut
);
  genvar gi;
  generate
    for (gi = 0; gi < NUM_STICKY; gi++) begin : g_bit
      // R2 and R4: an event always leaves the bit set
      a_r2_event_sets: assert property (@(posedge clk) disable iff (!rstN)
        evtPulse[gi] |=> statusView[gi+NUM_LEVEL]);
      // R2: a set bit holds unless it is cleared
      a_r2_sticky_hold: assert property (@(posedge clk) disable iff (!rstN)
        (statusView[gi+NUM_LEVEL] && !(wrEn && !wrAddr && wrData[gi+NUM_LEVEL]))
          |=> statusView[gi+NUM_LEVEL]);
      // R3: a one-write with no event clears the bit
      a_r3_clear: assert property (@(posedge clk) disable iff (!rstN)
        (wrEn && !wrAddr && wrData[gi+NUM_LEVEL] && !evtPulse[gi])
          |=> !statusView[gi+NUM_LEVEL]);
    end
  endgenerate

  // R8: packet done drives the line regardless of the mask
  a_r8_unmaskable: assert property (@(posedge clk) disable iff (!rstN)
    statusView[ALWAYS_ON_BIT] |=> irqOut);

  // R7: the line stays low when nothing enabled was pending
  a_r7_quiet: assert property (@(posedge clk) disable iff (!rstN)
    ((statusView & (maskView | FORCE_EN)) == '0) |=> !irqOut);

  // R6: the mask changes only on a mask write
  a_r6_mask_stable: assert property (@(posedge clk) disable iff (!rstN)
    !(wrEn && wrAddr) |=> $stable(maskView));
endmodule

bind irq_stat_unit irq_stat_unit_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .evtPulse   (evtPulse),
  .wrEn       (wrEn),
  .wrAddr     (wrAddr),
  .wrData     (wrData),
  .statusView (statusView),
  .maskView   (maskView),
  .irqOut     (irqOut)
);

// File: tb/irq_stat_unit_bench.sv
`timescale 1ns/1ps
module irq_stat_unit_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [5:0] evtPulse = '0;
  logic       txDataReq = 1'b0;
  logic       rxDataReq = 1'b0;
  logic       wrEn = 1'b0;
  logic       wrAddr = 1'b0;
  logic [7:0] wrData = '0;
  logic       rdAddr = 1'b0;
  logic [7:0] rdData;
  logic       irqOut;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  logic [5:0] mSticky = '0;
  logic [7:0] mMask = '0;
  logic       mIrq = 1'b0;

  always #2.5 clk = ~clk;

  irq_stat_unit u_irq_stat_unit (
    .clk(clk), .rstN(rstN), .evtPulse(evtPulse), .txDataReq(txDataReq),
    .rxDataReq(rxDataReq), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .irqOut(irqOut)
  );

  function automatic logic [7:0] expStatus(logic [5:0] st, logic tx, logic rx);
    return {st, tx, rx};
  endfunction

  function automatic logic expIrqNext(logic [5:0] st, logic tx, logic rx, logic [7:0] m);
    return |({st, tx, rx} & (m | 8'h80));
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One cycle: drive, clock edge, update the model, check after the edge
  task automatic step(logic [5:0] ev, logic we, logic wa, logic [7:0] wd,
                      logic tx, logic rx, logic ra, string req);
    evtPulse = ev; wrEn = we; wrAddr = wa; wrData = wd;
    txDataReq = tx; rxDataReq = rx; rdAddr = ra;
    @(posedge clk);
    mIrq = expIrqNext(mSticky, tx, rx, mMask);
    mSticky = (mSticky & ~((we && !wa) ? wd[7:2] : 6'h0)) | ev;
    if (we && wa) mMask = wd;
    #1;
    evtPulse = '0; wrEn = 1'b0;
    #0.5;
    check({req, " irq"}, {7'h0, irqOut}, {7'h0, mIrq});
    check({req, " read"}, rdData, ra ? mMask : expStatus(mSticky, tx, rx));
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] snap;
    void'($urandom(32'd9137));
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    check("R1 status", rdData, 8'h00);
    check("R1 irq", {7'h0, irqOut}, 8'h00);
    rdAddr = 1'b1; #0.5;
    check("R1 mask", rdData, 8'h00);
    @(negedge clk); rstN = 1'b1;
    @(negedge clk);

    // R9: a masked event is recorded, no interrupt
    step(6'b000100, 0, 0, 8'h00, 0, 0, 0, "R9");
    step(6'h00, 0, 0, 8'h00, 0, 0, 0, "R9");
    check("R9 masked bit set", rdData, 8'h10);
    check("R9 irq low", {7'h0, irqOut}, 8'h00);

    // R6: enable bit 4, R7: irq rises one cycle after the write
    step(6'h00, 1, 1, 8'h10, 0, 0, 1, "R6");
    check("R6 mask readback", rdData, 8'h10);
    check("R7 not yet", {7'h0, irqOut}, 8'h00);
    step(6'h00, 0, 0, 8'h00, 0, 0, 0, "R7");
    check("R7 raised", {7'h0, irqOut}, 8'h01);

    // R4: clear and event on bit 4 together -> stays set
    step(6'b000100, 1, 0, 8'h10, 0, 0, 0, "R4");
    check("R4 event wins", rdData, 8'h10);

    // R3: write back read value clears exactly those bits
    step(6'b001001, 0, 0, 8'h00, 0, 0, 0, "R3");
    snap = rdData;
    step(6'h00, 1, 0, snap, 0, 0, 0, "R3");
    check("R3 cleared", rdData, 8'h00);

    // R5: level bits follow inputs and ignore clears
    step(6'h00, 1, 0, 8'hFF, 1, 1, 0, "R5");
    check("R5 levels live", rdData, 8'h03);
    step(6'h00, 1, 0, 8'h03, 1, 0, 0, "R5");
    check("R5 clear ignored", rdData, 8'h02);

    // R8: packet done with every mask bit zero
    step(6'h00, 1, 1, 8'h00, 0, 0, 0, "R8");
    step(6'b100000, 0, 0, 8'h00, 0, 0, 0, "R8");
    check("R8 not yet", {7'h0, irqOut}, 8'h00);
    step(6'h00, 0, 0, 8'h00, 0, 0, 0, "R8");
    check("R8 unmaskable", {7'h0, irqOut}, 8'h01);
    step(6'h00, 1, 0, 8'h80, 0, 0, 0, "R8");

    // Random traffic: R2 R3 R6 R7 together
    for (int i = 0; i < 3000; i++) begin
      logic [5:0] ev;
      logic we, wa, ra;
      logic [7:0] wd;
      ev = 6'($urandom & $urandom & $urandom);
      we = ($urandom_range(0, 3) == 0);
      wa = $urandom_range(0, 2) == 0;
      ra = $urandom_range(0, 1);
      if (!wa && $urandom_range(0, 1) == 1) wd = expStatus(mSticky, txDataReq, rxDataReq);
      else wd = 8'($urandom);
      step(ev, we, wa, wd, $urandom_range(0, 1), $urandom_range(0, 1), ra,
           ra ? "R6 random" : "R2 random");
    end

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule